// File: doc/BRIEF.md
# Vector MMIO Burst Load Sequencer

This block carries out one vector load aimed at a memory-mapped peripheral, with caching bypassed. After a one-cycle start it issues a series of single-word reads on a request/response bus. Each read finishes before the next one starts, and the reads go out in element order. Each returned word is written into a small destination register file, at a slot counted from a base index. The register file can be read back through a synchronous read port.

The address comes from a register value and never from an immediate. In splat mode every element reads the same base address, so a peripheral that is read repeatedly returns one fresh word per element. In indexed mode element i reads from the base address plus its own index taken from an index vector.

An optional predicate-result mode tests each returned word. It ends the burst at the first zero word and reports a shortened vector length, so the caller needs no branch to stop a NULL-terminated read stream.

Top module: `mmio_burst_loader`

## Requirements
- R1: In splat mode (`splat_i`=1) every element issues its own bus read, and each of those reads is to the captured base address.
- R2: Only one read is in flight at a time. The request for element i+1 is raised in the cycle after the response for element i is accepted, and reads go out in element order 0, 1, 2, ...
- R3: In indexed mode element i reads from base + index[i]. index[i] is the field `idx_vec_i[i*IDX_W +: IDX_W]`, zero-extended. The sum is unsigned and wraps modulo 2^ADDR_W.
- R4: The word for element i is written to register (dst_base + i) mod NREG. A register presented on `rd_idx_i` appears on `rd_data_o` one clock later.
- R5: With `pred_i`=1 the first zero response ends the burst. The zero word is not written, no further read is issued, and `vl_out_o` equals the number of elements before the zero.
- R6: With no zero response, or with `pred_i`=0, the burst runs to the full length and `vl_out_o` equals that length. With `pred_i`=0, zero words are written like any other value.
- R7: `done_o` is a one-cycle pulse in the cycle after the final response handshake. `busy_o` is low from that cycle on.
- R8: A start with a length of zero produces `done_o` with `vl_out_o`=0 in the next cycle, and no bus request.
- R9: A requested length above MAX_VL is clamped to MAX_VL.
- R10: A raised request keeps `req_valid_o` high and `req_addr_o` unchanged until `req_ready_i` accepts it.
- R11: A start pulse that arrives while a burst is in progress is ignored. All start inputs are captured at the accepted start.
- R12: After reset `req_valid_o`, `rsp_ready_o`, `busy_o` and `done_o` are low and `vl_out_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for one vector load |
| splat_i | input | 1 | 1: all elements read the base address; 0: indexed |
| pred_i | input | 1 | 1: stop at the first zero response |
| vl_i | input | VL_W | Requested vector length |
| base_addr_i | input | ADDR_W | Base address taken from a register |
| idx_vec_i | input | MAX_VL*IDX_W | Per-element index vector, element i at bits i*IDX_W |
| dst_base_i | input | RIDX_W | First destination register |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle completion pulse |
| vl_out_o | output | VL_W | Resulting vector length, valid with done_o |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | ADDR_W | Read address |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_ready_o | output | 1 | Sequencer waiting for read data |
| rsp_data_i | input | DATA_W | Read data |
| rd_idx_i | input | RIDX_W | Register file read index |
| rd_data_o | output | DATA_W | Register file read data, one cycle later |

## Verification
A wrong element counter or a wrong address-select would show on `req_addr_o` in the same cycle the request is raised. The bench therefore compares the address on every clock in which a request is pending. A wrong state transition would show within one clock as a request overlapping an outstanding response, or as a misplaced `done_o`. A wrong truncation count would show on `vl_out_o` in the pulse cycle. A wrong write index or a stray write of the zero word would only show when the register file is read back, which the bench does after every burst.

// File: rtl/mbl_pkg.sv
package mbl_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_RSP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mbl_addr_gen.sv
// Element address: shared base in splat mode, base + zero-extended index otherwise.
module mbl_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16,
  parameter int MAX_VL = 8,
  localparam int EL_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic                     splat,
  input  logic [ADDR_W-1:0]        base,
  input  logic [MAX_VL*IDX_W-1:0]  idx_flat,
  input  logic [EL_W-1:0]          elem,
  output logic [ADDR_W-1:0]        addr
);
  logic [IDX_W-1:0] idx_arr [MAX_VL];

  for (genvar g = 0; g < MAX_VL; g++) begin : g_unpack
    assign idx_arr[g] = idx_flat[g*IDX_W +: IDX_W];
  end

  always_comb begin
    if (splat) addr = base;
    else       addr = base + ADDR_W'(idx_arr[elem]);
  end
endmodule

// File: rtl/mbl_regfile.sv
// Destination registers: one synchronous write port, one registered read port.
module mbl_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RIDX_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mmio_burst_loader.sv
module mmio_burst_loader
  import mbl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 16,
  parameter int MAX_VL = 8,
  parameter int NREG   = 16,
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int EL_W   = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    splat_i,
  input  logic                    pred_i,
  input  logic [VL_W-1:0]         vl_i,
  input  logic [ADDR_W-1:0]       base_addr_i,
  input  logic [MAX_VL*IDX_W-1:0] idx_vec_i,
  input  logic [RIDX_W-1:0]       dst_base_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [VL_W-1:0]         vl_out_o,
  output logic                    req_valid_o,
  input  logic                    req_ready_i,
  output logic [ADDR_W-1:0]       req_addr_o,
  input  logic                    rsp_valid_i,
  output logic                    rsp_ready_o,
  input  logic [DATA_W-1:0]       rsp_data_i,
  input  logic [RIDX_W-1:0]       rd_idx_i,
  output logic [DATA_W-1:0]       rd_data_o
);
  seq_state_e              state_q;
  logic [VL_W-1:0]         elem_q;
  logic [VL_W-1:0]         vl_q;
  logic                    splat_q;
  logic                    pred_q;
  logic [ADDR_W-1:0]       base_q;
  logic [MAX_VL*IDX_W-1:0] idx_q;
  logic [RIDX_W-1:0]       dbase_q;
  logic [ADDR_W-1:0]       addr_q;
  logic                    done_q;
  logic [VL_W-1:0]         vl_out_q;

  logic [VL_W-1:0]         vl_eff;
  logic [VL_W-1:0]         elem_nxt;
  logic                    idle;
  logic                    rsp_hs;
  logic                    zero_hit;
  logic                    last_elem;
  logic                    ag_splat;
  logic [ADDR_W-1:0]       ag_base;
  logic [MAX_VL*IDX_W-1:0] ag_idx;
  logic [EL_W-1:0]         ag_elem;
  logic [ADDR_W-1:0]       ag_addr;
  logic                    rf_we;
  logic [RIDX_W-1:0]       rf_waddr;

  assign idle      = (state_q == SEQ_IDLE);
  assign vl_eff    = (vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_i;
  assign elem_nxt  = elem_q + VL_W'(1);
  assign rsp_hs    = (state_q == SEQ_RSP) && rsp_valid_i;
  assign zero_hit  = pred_q && (rsp_data_i == '0);
  assign last_elem = (elem_nxt == vl_q);

  // While idle the generator sees the start inputs (element 0);
  // otherwise the captured request and the following element.
  assign ag_splat = idle ? splat_i     : splat_q;
  assign ag_base  = idle ? base_addr_i : base_q;
  assign ag_idx   = idle ? idx_vec_i   : idx_q;
  assign ag_elem  = idle ? '0          : EL_W'(elem_nxt);

  mbl_addr_gen #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .MAX_VL (MAX_VL)
  ) u_addr (
    .splat    (ag_splat),
    .base     (ag_base),
    .idx_flat (ag_idx),
    .elem     (ag_elem),
    .addr     (ag_addr)
  );

  assign rf_we    = rsp_hs && !zero_hit;
  assign rf_waddr = dbase_q + RIDX_W'(elem_q);

  mbl_regfile #(
    .DATA_W (DATA_W),
    .NREG   (NREG)
  ) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rsp_data_i),
    .raddr (rd_idx_i),
    .rdata (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      elem_q   <= '0;
      vl_q     <= '0;
      splat_q  <= 1'b0;
      pred_q   <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      dbase_q  <= '0;
      addr_q   <= '0;
      done_q   <= 1'b0;
      vl_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            if (vl_eff == '0) begin
              done_q   <= 1'b1;
              vl_out_q <= '0;
            end else begin
              splat_q <= splat_i;
              pred_q  <= pred_i;
              base_q  <= base_addr_i;
              idx_q   <= idx_vec_i;
              dbase_q <= dst_base_i;
              vl_q    <= vl_eff;
              elem_q  <= '0;
              addr_q  <= ag_addr;
              state_q <= SEQ_REQ;
            end
          end
        end
        SEQ_REQ: begin
          if (req_ready_i) state_q <= SEQ_RSP;
        end
        SEQ_RSP: begin
          if (rsp_valid_i) begin
            if (zero_hit) begin
              done_q   <= 1'b1;
              vl_out_q <= elem_q;
              state_q  <= SEQ_IDLE;
            end else if (last_elem) begin
              done_q   <= 1'b1;
              vl_out_q <= vl_q;
              state_q  <= SEQ_IDLE;
            end else begin
              elem_q  <= elem_nxt;
              addr_q  <= ag_addr;
              state_q <= SEQ_REQ;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o      = !idle;
  assign done_o      = done_q;
  assign vl_out_o    = vl_out_q;
  assign req_valid_o = (state_q == SEQ_REQ);
  assign req_addr_o  = addr_q;
  assign rsp_ready_o = (state_q == SEQ_RSP);
endmodule

// File: rtl/mbl_checker.sv
module mbl_checker #(
  parameter int ADDR_W = 32,
  parameter int VL_W   = 4,
  parameter int MAX_VL = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [VL_W-1:0]   vl_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [VL_W-1:0]   vl_out_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              rsp_ready_o,
  input logic              splat_q,
  input logic [ADDR_W-1:0] base_q
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_ready_o |-> !req_valid_o);

  assert_splat_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && splat_q) |-> (req_addr_o == base_q));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_zero_vl_R8: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (vl_i == '0)) |=> (done_o && (vl_out_o == '0) && !req_valid_o));

  assert_vl_clamp_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (vl_out_o <= VL_W'(MAX_VL)));
endmodule

bind mmio_burst_loader mbl_checker #(
  .ADDR_W (ADDR_W),
  .VL_W   (VL_W),
  .MAX_VL (MAX_VL)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .vl_i        (vl_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .vl_out_o    (vl_out_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .rsp_ready_o (rsp_ready_o),
  .splat_q     (splat_q),
  .base_q      (base_q)
);

// File: tb/tb_mmio_burst_loader.sv
module tb_mmio_burst_loader;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 16;
  localparam int MAX_VL = 8;
  localparam int NREG   = 16;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int RIDX_W = $clog2(NREG);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, splat_i = 1'b0, pred_i = 1'b0;
  logic [VL_W-1:0] vl_i = '0;
  logic [ADDR_W-1:0] base_addr_i = '0;
  logic [MAX_VL*IDX_W-1:0] idx_vec_i = '0;
  logic [RIDX_W-1:0] dst_base_i = '0;
  logic busy_o, done_o, req_valid_o, rsp_ready_o;
  logic [VL_W-1:0] vl_out_o;
  logic req_ready_i = 1'b0, rsp_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_o;
  logic [DATA_W-1:0] rsp_data_i = '0;
  logic [RIDX_W-1:0] rd_idx_i = '0;
  logic [DATA_W-1:0] rd_data_o;

  always #(CLK_P/2) clk = ~clk;

  mmio_burst_loader #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .MAX_VL(MAX_VL), .NREG(NREG)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .splat_i(splat_i), .pred_i(pred_i),
    .vl_i(vl_i), .base_addr_i(base_addr_i), .idx_vec_i(idx_vec_i), .dst_base_i(dst_base_i),
    .busy_o(busy_o), .done_o(done_o), .vl_out_o(vl_out_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .rsp_valid_i(rsp_valid_i), .rsp_ready_o(rsp_ready_o), .rsp_data_i(rsp_data_i),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] mdl_rf [NREG];
  bit                mdl_known [NREG];
  logic [IDX_W-1:0]  t_idx [MAX_VL];
  logic [DATA_W-1:0] t_dat [MAX_VL];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One burst: behavioural reference (phase 0 request, 1 response, 2 done)
  // compared with the ports on every falling edge.
  task automatic run_burst(input bit splat, input bit pred, input int vl,
                           input logic [ADDR_W-1:0] base, input int dbase,
                           input int rsp_lat, input bit poke, input string vl_tag);
    logic [ADDR_W-1:0] exp_addr [MAX_VL];
    int eff, exp_reads, exp_vl, k, lat, cyc, phase;
    bit rdy, vld;
    eff = (vl > MAX_VL) ? MAX_VL : vl;
    exp_reads = eff;
    exp_vl = eff;
    for (int i = 0; i < eff; i++) begin
      exp_addr[i] = splat ? base : base + {{(ADDR_W-IDX_W){1'b0}}, t_idx[i]};
      if (pred && t_dat[i] == '0) begin
        exp_reads = i + 1;
        exp_vl = i;
        break;
      end
      mdl_rf[(dbase + i) % NREG] = t_dat[i];
      mdl_known[(dbase + i) % NREG] = 1'b1;
    end
    start_i = 1'b1; splat_i = splat; pred_i = pred; vl_i = VL_W'(vl);
    base_addr_i = base; dst_base_i = RIDX_W'(dbase);
    for (int i = 0; i < MAX_VL; i++) idx_vec_i[i*IDX_W +: IDX_W] = t_idx[i];
    @(negedge clk);
    start_i = 1'b0;
    base_addr_i = 32'h5A5A_0000;   // inputs change after start (R11)
    idx_vec_i = '1;
    phase = (eff == 0) ? 2 : 0;
    k = 0; lat = 0; cyc = 0;
    while (1) begin
      chk(done_o == (phase == 2), "R7", done_o, phase == 2);
      if (phase == 2) begin
        chk(vl_out_o == VL_W'(exp_vl), vl_tag, vl_out_o, exp_vl);
        chk(k == exp_reads, "R2", k, exp_reads);
        chk(!busy_o, "R7", busy_o, 0);
        break;
      end
      chk(req_valid_o == (phase == 0), (eff == 0) ? "R8" : "R2", req_valid_o, phase == 0);
      chk(rsp_ready_o == (phase == 1), "R2", rsp_ready_o, phase == 1);
      chk(busy_o, "R11", busy_o, 1);
      if (phase == 0)
        chk(req_addr_o == exp_addr[k], splat ? "R1" : "R3", req_addr_o, exp_addr[k]);
      rdy = (phase == 0) && (cyc % 3 != 1);
      vld = (phase == 1) && (lat >= rsp_lat);
      req_ready_i = rdy;
      rsp_valid_i = vld;
      rsp_data_i = vld ? t_dat[k] : 32'hBAD0_BAD0;
      if (poke && cyc == 2) begin
        start_i = 1'b1; splat_i = 1'b1; vl_i = VL_W'(2); dst_base_i = RIDX_W'(9);
      end else start_i = 1'b0;
      @(posedge clk);
      if (phase == 0 && rdy) begin phase = 1; lat = 0; end
      else if (phase == 1) begin
        if (vld) begin
          phase = (k + 1 == exp_reads) ? 2 : 0;
          k++;
        end else lat++;
      end
      cyc++;
      @(negedge clk);
      start_i = 1'b0;
      if (cyc > 400) begin
        chk(1'b0, "R7 burst watchdog", cyc, 0);
        break;
      end
    end
    req_ready_i = 1'b0;
    rsp_valid_i = 1'b0;
    @(negedge clk);
    chk(!done_o, "R7", done_o, 0);
    for (int r = 0; r < NREG; r++) begin
      if (mdl_known[r]) begin
        rd_idx_i = RIDX_W'(r);
        @(negedge clk);
        chk(rd_data_o == mdl_rf[r], "R4", rd_data_o, mdl_rf[r]);
      end
    end
  endtask

  task automatic fill(input logic [DATA_W-1:0] seed);
    for (int i = 0; i < MAX_VL; i++) begin
      t_dat[i] = seed + DATA_W'(i * 16'h0101);
      t_idx[i] = IDX_W'(i * 8 + 4);
    end
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) mdl_known[r] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: state out of reset
    chk(!req_valid_o, "R12", req_valid_o, 0);
    chk(!rsp_ready_o, "R12", rsp_ready_o, 0);
    chk(!busy_o, "R12", busy_o, 0);
    chk(!done_o, "R12", done_o, 0);
    chk(vl_out_o == '0, "R12", vl_out_o, 0);

    // R1: splat, full length
    fill(32'hA100_0000);
    run_burst(1, 0, 4, 32'h4000_0010, 0, 0, 0, "R6");
    // R3: indexed with response latency
    fill(32'hB200_0000);
    t_idx[2] = 16'hFFFF;
    run_burst(0, 0, 5, 32'h0000_1000, 3, 2, 0, "R6");
    // R3 address wrap, R4 register wrap
    fill(32'hC300_0000);
    t_idx[0] = 16'h0020;
    run_burst(0, 0, 8, 32'hFFFF_FFF0, 12, 1, 0, "R6");
    // R5: predicate stop at element 3
    fill(32'hD400_0000);
    t_dat[3] = '0;
    run_burst(1, 1, 7, 32'h2000_0000, 4, 0, 0, "R5");
    // R5: zero at first element
    fill(32'hE500_0000);
    t_dat[0] = '0;
    run_burst(0, 1, 6, 32'h0300_0000, 6, 1, 0, "R5");
    // R6: predicate mode without zero
    fill(32'hF600_0000);
    run_burst(0, 1, 6, 32'h0000_8000, 1, 0, 0, "R6");
    // R6: zeros written when predicate off
    fill(32'h1700_0000);
    t_dat[1] = '0; t_dat[2] = '0;
    run_burst(1, 0, 3, 32'h0000_0040, 14, 0, 0, "R6");
    // R8: zero length
    run_burst(1, 0, 0, 32'h0000_0080, 0, 0, 0, "R8");
    // R9: clamp
    fill(32'h2800_0000);
    run_burst(0, 0, 13, 32'h0001_0000, 5, 0, 0, "R9");
    // R11: start while busy ignored
    fill(32'h3900_0000);
    run_burst(0, 0, 5, 32'h0002_0000, 8, 3, 1, "R11");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule